// File: doc/BRIEF.md
# Programmable Interrupt Steering Crossbar

This block collects sixteen level-sensitive device interrupt requests and forwards each one to one of three CPU interrupt lines. The sources come in three groups (seven on the PCI side, six local peripherals and three on the ISA side). Each group has a status/enable register. A write to it sets the group's enable mask, and a read returns the group's raw request levels. Software applies the enable mask itself when it decides which sources are active.

Five crossbar registers hold a 2-bit destination code for every source. A CPU line is raised when at least one source is requesting, is enabled, and carries that line's code. A separate panic register keeps five fatal-condition causes as sticky bits. Any set cause raises a dedicated high-priority line. Software clears causes by writing back a mask of the bits it wants cleared. Everything is accessed over a plain 32-bit word-offset read/write bus.

Top module: `irq_steer_xbar`

## Requirements
- R1: `src_in` bits 0-6 form the PCI group, bits 7-12 the local group and bits 13-15 the ISA group; group source k is the k-th bit of its group. Word offsets: 0 PCI, 1 local, 2 ISA, 3 keyboard, 4 panic, 5-9 crossbar; a write to offsets 0-2 sets that group's enable mask from the low data bits (bit k enables source k).
- R2: Group source k takes its destination from crossbar register base+k/4, bits [2*(k%4)+1 : 2*(k%4)], with base offset 5 for PCI, 7 for local and 9 for ISA; reading a crossbar register returns the stored fields, and slots with no source read zero.
- R3: `cpu_irq[l]` is high in the cycle after a clock edge at which some source is high, enabled and has code l, and low after an edge at which none is.
- R4: Destination code 3 forwards the source to no line.
- R5: Reading offsets 0-2 returns the group's raw request levels (bit k = source k), regardless of its enable mask; `bus_rdata` reflects the offset and inputs present at the previous clock edge.
- R6: `panic_evt` bits (0 I/O parity error, 1 ISA NMI, 2 bus error, 3 power failure, 4 debug switch) are single-cycle pulses that set sticky bits readable at offset 4; `panic_irq` is high from the edge that latches a cause for as long as any cause remains set.
- R7: A write to offset 4 clears exactly the cause bits set in the written data; when a pulse and a clear hit the same bit in one cycle, the bit stays set.
- R8: After reset, all enables, crossbar fields and panic causes are zero and every output is low.
- R9: Offsets 10-15 read zero and ignore writes; the keyboard offset has no routed sources, reads zero and its writes change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_in | input | 16 | Level interrupt requests, grouped per R1 |
| panic_evt | input | 5 | Fatal-cause pulses, bit meaning per R6 |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 4 | Word offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cpu_irq | output | 3 | Steered CPU interrupt lines 0-2 |
| panic_irq | output | 1 | High-priority panic line |

## Verification
Every result here is due exactly one clock edge after its cause. Routed lines follow the request and enable state at the edge. Read data follows the offset and the inputs at the edge. The panic line follows the edge that latches a pulse or applies a clear. The bench drives all inputs on the falling edge and lets one rising edge pass. It samples on the next falling edge and never holds a stimulus over two edges, so an extra or missing register stage shows up as a mismatch.

// File: rtl/irq_steer_pkg.sv
package irq_steer_pkg;
  localparam int FIELD_W   = 2;
  localparam int SLOTS     = 4;
  localparam int ADR_PCI   = 0;
  localparam int ADR_LOC   = 1;
  localparam int ADR_ISA   = 2;
  localparam int ADR_KBD   = 3;
  localparam int ADR_PANIC = 4;
  localparam int ADR_XBAR0 = 5;

  function automatic int regs_for(input int n);
    return (n + SLOTS - 1) / SLOTS;
  endfunction

  // index of a source inside its own group
  function automatic int src_index(input int i, input int np, input int nl);
    if (i < np) return i;
    else if (i < np + nl) return i - np;
    else return i - np - nl;
  endfunction

  // crossbar register (0-based) that holds the source's field
  function automatic int src_xreg(input int i, input int np, input int nl);
    int base;
    if (i < np) base = 0;
    else if (i < np + nl) base = regs_for(np);
    else base = regs_for(np) + regs_for(nl);
    return base + src_index(i, np, nl) / SLOTS;
  endfunction

  function automatic int src_slot(input int i, input int np, input int nl);
    return src_index(i, np, nl) % SLOTS;
  endfunction
endpackage

// File: rtl/irq_steer_regs.sv
module irq_steer_regs
  import irq_steer_pkg::*;
#(
  parameter int NP   = 7,
  parameter int NL   = 6,
  parameter int NI   = 3,
  parameter int NPAN = 5,
  parameter int AW   = 4,
  parameter int DW   = 32,
  localparam int NS  = NP + NL + NI
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  input  logic [NPAN-1:0]      panic_evt,
  output logic [NS-1:0]        en_all,
  output logic [FIELD_W*NS-1:0] codes,
  output logic [NPAN-1:0]      panic_q,
  output logic                 panic_irq
);
  logic [NP-1:0]   en_pci;
  logic [NL-1:0]   en_loc;
  logic [NI-1:0]   en_isa;
  logic [NPAN-1:0] clr_mask;
  logic [NPAN-1:0] panic_d;

  assign en_all = {en_isa, en_loc, en_pci};

  always_ff @(posedge clk) begin
    if (rst) begin
      en_pci <= '0;
      en_loc <= '0;
      en_isa <= '0;
    end else if (we) begin
      if (addr == AW'(ADR_PCI)) en_pci <= wdata[NP-1:0];
      if (addr == AW'(ADR_LOC)) en_loc <= wdata[NL-1:0];
      if (addr == AW'(ADR_ISA)) en_isa <= wdata[NI-1:0];
    end
  end

  // one field register per source, placed by its group position
  for (genvar i = 0; i < NS; i++) begin : g_field
    localparam int XR = src_xreg(i, NP, NL);
    localparam int SL = src_slot(i, NP, NL);
    always_ff @(posedge clk) begin
      if (rst)
        codes[FIELD_W*i +: FIELD_W] <= '0;
      else if (we && addr == AW'(ADR_XBAR0 + XR))
        codes[FIELD_W*i +: FIELD_W] <= wdata[FIELD_W*SL +: FIELD_W];
    end
  end

  // sticky causes: new pulses override a simultaneous clear
  always_comb begin
    clr_mask = (we && addr == AW'(ADR_PANIC)) ? wdata[NPAN-1:0] : '0;
    panic_d  = (panic_q & ~clr_mask) | panic_evt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      panic_q   <= '0;
      panic_irq <= 1'b0;
    end else begin
      panic_q   <= panic_d;
      panic_irq <= |panic_d;
    end
  end
endmodule

// File: rtl/irq_steer_route.sv
module irq_steer_route
  import irq_steer_pkg::*;
#(
  parameter int NS     = 16,
  parameter int NLINES = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NS-1:0]         src,
  input  logic [NS-1:0]         en,
  input  logic [FIELD_W*NS-1:0] codes,
  output logic [NLINES-1:0]     cpu_irq
);
  logic [NS-1:0] live;
  assign live = src & en;

  for (genvar l = 0; l < NLINES; l++) begin : g_line
    logic [NS-1:0] sel;
    for (genvar i = 0; i < NS; i++) begin : g_src
      assign sel[i] = (codes[FIELD_W*i +: FIELD_W] == FIELD_W'(l));
    end
    always_ff @(posedge clk) begin
      if (rst) cpu_irq[l] <= 1'b0;
      else     cpu_irq[l] <= |(live & sel);
    end
  end
endmodule

// File: rtl/irq_steer_xbar.sv
module irq_steer_xbar
  import irq_steer_pkg::*;
#(
  parameter int NP     = 7,
  parameter int NL     = 6,
  parameter int NI     = 3,
  parameter int NPAN   = 5,
  parameter int NLINES = 3,
  parameter int AW     = 4,
  parameter int DW     = 32,
  localparam int NS     = NP + NL + NI,
  localparam int N_XBAR = regs_for(NP) + regs_for(NL) + regs_for(NI),
  localparam int XW     = (N_XBAR > 1) ? $clog2(N_XBAR) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NS-1:0]     src_in,
  input  logic [NPAN-1:0]   panic_evt,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NLINES-1:0] cpu_irq,
  output logic              panic_irq
);
  logic [NS-1:0]         en_all;
  logic [FIELD_W*NS-1:0] codes;
  logic [NPAN-1:0]       panic_q;
  logic [FIELD_W*SLOTS-1:0] xview [N_XBAR];
  logic [DW-1:0]         rd_d;
  logic [XW-1:0]         xidx;

  irq_steer_regs #(
    .NP(NP), .NL(NL), .NI(NI), .NPAN(NPAN), .AW(AW), .DW(DW)
  ) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .panic_evt(panic_evt), .en_all(en_all), .codes(codes),
    .panic_q(panic_q), .panic_irq(panic_irq)
  );

  irq_steer_route #(.NS(NS), .NLINES(NLINES)) u_route (
    .clk(clk), .rst(rst), .src(src_in), .en(en_all), .codes(codes),
    .cpu_irq(cpu_irq)
  );

  // reassemble crossbar words; slots without a source stay zero
  always_comb begin
    for (int r = 0; r < N_XBAR; r++) xview[r] = '0;
    for (int i = 0; i < NS; i++)
      xview[src_xreg(i, NP, NL)][FIELD_W*src_slot(i, NP, NL) +: FIELD_W] =
        codes[FIELD_W*i +: FIELD_W];
  end

  assign xidx = XW'(bus_addr - AW'(ADR_XBAR0));

  always_comb begin
    rd_d = '0;
    if (bus_addr == AW'(ADR_PCI))        rd_d = DW'(src_in[NP-1:0]);
    else if (bus_addr == AW'(ADR_LOC))   rd_d = DW'(src_in[NP +: NL]);
    else if (bus_addr == AW'(ADR_ISA))   rd_d = DW'(src_in[NP+NL +: NI]);
    else if (bus_addr == AW'(ADR_PANIC)) rd_d = DW'(panic_q);
    else if (bus_addr >= AW'(ADR_XBAR0) && bus_addr < AW'(ADR_XBAR0 + N_XBAR))
      rd_d = DW'(xview[xidx]);
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_d;
  end
endmodule

// File: rtl/irq_steer_chk.sv
module irq_steer_chk
  import irq_steer_pkg::*;
#(
  parameter int NS     = 16,
  parameter int NPAN   = 5,
  parameter int NLINES = 3,
  parameter int AW     = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [NS-1:0]     src_in,
  input logic [NPAN-1:0]   panic_evt,
  input logic              bus_we,
  input logic [AW-1:0]     bus_addr,
  input logic [NPAN-1:0]   clr_data,
  input logic [NLINES-1:0] cpu_irq,
  input logic              panic_irq
);
  // R3: with no request at an edge, no line is raised after it
  a_r3_idle_lines: assert property (@(posedge clk) disable iff (rst)
    (src_in == '0) |=> (cpu_irq == '0));

  // R8: reset leaves every output low
  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> (cpu_irq == '0 && !panic_irq));

  // R6: any cause pulse raises the panic line at the next sample
  a_r6_panic_raise: assert property (@(posedge clk) disable iff (rst)
    (panic_evt != '0) |=> panic_irq);

  // R7: clearing every cause with no new pulse drops the line
  a_r7_clear_all: assert property (@(posedge clk) disable iff (rst)
    (bus_we && bus_addr == AW'(ADR_PANIC) && clr_data == '1 && panic_evt == '0)
      |=> !panic_irq);
endmodule

bind irq_steer_xbar irq_steer_chk #(
  .NS(NS), .NPAN(NPAN), .NLINES(NLINES), .AW(AW)
) u_chk (
  .clk(clk), .rst(rst), .src_in(src_in), .panic_evt(panic_evt),
  .bus_we(bus_we), .bus_addr(bus_addr), .clr_data(bus_wdata[NPAN-1:0]),
  .cpu_irq(cpu_irq), .panic_irq(panic_irq)
);

// File: tb/irq_steer_xbar_test.sv
module irq_steer_xbar_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] src_in = '0;
  logic [4:0]  panic_evt = '0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  cpu_irq;
  logic        panic_irq;

  irq_steer_xbar uut (
    .clk(clk), .rst(rst), .src_in(src_in), .panic_evt(panic_evt),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .cpu_irq(cpu_irq), .panic_irq(panic_irq)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [6:0]  m_pci = '0;
  logic [5:0]  m_loc = '0;
  logic [2:0]  m_isa = '0;
  logic [31:0] m_xc  = '0;
  logic [4:0]  m_pan = '0;

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = 4'(a); bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 4'(a);
    tick();
    d = bus_rdata;
  endtask

  function automatic logic [2:0] exp_lines(input logic [15:0] s);
    logic [15:0] en;
    logic [2:0]  r;
    en = {m_isa, m_loc, m_pci};
    r = '0;
    for (int i = 0; i < 16; i++)
      if (s[i] && en[i] && m_xc[2*i +: 2] != 2'd3) r[m_xc[2*i +: 2]] = 1'b1;
    return r;
  endfunction

  function automatic logic [31:0] xbar_word(input int r);
    logic [31:0] w;
    int k, b;
    w = '0;
    for (int i = 0; i < 16; i++) begin
      if (i < 7)       begin k = i;      b = 0; end
      else if (i < 13) begin k = i - 7;  b = 2; end
      else             begin k = i - 13; b = 4; end
      if (b + k / 4 == r) w[2*(k%4) +: 2] = m_xc[2*i +: 2];
    end
    return w;
  endfunction

  task automatic program_all();
    wr(0, 32'(m_pci)); wr(1, 32'(m_loc)); wr(2, 32'(m_isa));
    for (int r = 0; r < 5; r++) wr(5 + r, xbar_word(r));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    int unused_seed;
    unused_seed = $urandom(32'd4242);
    @(negedge clk); tick(); tick();
    rst = 1'b0;
    tick();

    // R8: reset state
    check("R8 lines", 32'(cpu_irq), 0);
    check("R8 panic line", 32'(panic_irq), 0);
    for (int a = 0; a < 10; a++) begin
      rd(a, v);
      check("R8 register zero", v, 0);
    end
    src_in = 16'hffff; tick();
    check("R8 nothing forwarded", 32'(cpu_irq), 0);

    // R3/R1: PCI source 0 to line 1
    src_in = '0;
    m_pci = 7'h01; m_xc = '0; m_xc[1:0] = 2'd1;
    program_all();
    src_in = 16'h0001; tick();
    check("R3 pci0 to line1", 32'(cpu_irq), 3'b010);
    src_in = '0; tick();
    check("R3 released", 32'(cpu_irq), 0);

    // R2: ISA source 2 (global 15) to line 2 via offset 9 slot 2
    m_isa = 3'b100; m_xc[31:30] = 2'd2;
    program_all();
    rd(9, v);
    check("R2 isa xbar readback", v, 32'h20);
    src_in = 16'h8000; tick();
    check("R2 isa2 to line2", 32'(cpu_irq), 3'b100);

    // R4: code 3 routes nowhere
    m_xc[31:30] = 2'd3; wr(9, xbar_word(4)); tick();
    check("R4 code3 no line", 32'(cpu_irq), 0);

    // R5: raw pending with enables off
    m_pci = '0; m_loc = '0; m_isa = '0; program_all();
    src_in = 16'b101_010011_1010101; tick();
    check("R5 lines off when disabled", 32'(cpu_irq), 0);
    rd(0, v); check("R5 pci raw", v, 32'h55);
    rd(1, v); check("R5 local raw", v, 32'h13);
    rd(2, v); check("R5 isa raw", v, 32'h5);

    // R2: unused slots read zero after writing ones
    wr(6, 32'hffff_ffff); rd(6, v);
    check("R2 pci reg1 unused slot", v, 32'h3f);
    wr(8, 32'hffff_ffff); rd(8, v);
    check("R2 local reg1 unused slots", v, 32'h0f);

    // R9: keyboard and unmapped offsets
    m_xc[13:8] = 6'h3f; m_xc[25:22] = 4'hf;
    wr(3, 32'hffff_ffff); rd(3, v); check("R9 keyboard reads zero", v, 0);
    wr(12, 32'hffff_ffff); rd(12, v); check("R9 unmapped reads zero", v, 0);
    for (int r = 0; r < 5; r++) begin
      rd(5 + r, v); check("R9 crossbar unchanged", v, xbar_word(r));
    end

    // R3 random routing
    for (int it = 0; it < 150; it++) begin
      m_pci = 7'($urandom); m_loc = 6'($urandom); m_isa = 3'($urandom);
      m_xc  = $urandom;
      if (it % 10 == 0) m_xc = '0;
      program_all();
      src_in = 16'($urandom);
      if (it % 7 == 0) src_in = 16'hffff;
      tick();
      check("R3 random route", 32'(cpu_irq), 32'(exp_lines(src_in)));
      bus_addr = 4'(it % 3);
      tick();
      if (it % 3 == 0)      check("R5 random pci read", bus_rdata, 32'(src_in[6:0]));
      else if (it % 3 == 1) check("R5 random local read", bus_rdata, 32'(src_in[12:7]));
      else                  check("R5 random isa read", bus_rdata, 32'(src_in[15:13]));
    end
    src_in = '0;

    // R6 / R7 panic causes
    panic_evt = 5'b00100; tick(); panic_evt = '0;
    check("R6 panic line set", 32'(panic_irq), 1);
    panic_evt = 5'b10000; tick(); panic_evt = '0;
    rd(4, v); check("R6 sticky causes", v, 32'h14);
    wr(4, 32'h01); rd(4, v);
    check("R7 clear other bit keeps", v, 32'h14);
    check("R7 line stays", 32'(panic_irq), 1);
    wr(4, 32'h04); rd(4, v);
    check("R7 clear one bit", v, 32'h10);
    bus_we = 1'b1; bus_addr = 4'd4; bus_wdata = 32'h12; panic_evt = 5'b00010;
    tick();
    bus_we = 1'b0; panic_evt = '0;
    rd(4, v); check("R7 set wins over clear", v, 32'h02);
    wr(4, 32'h1f);
    check("R7 all cleared line low", 32'(panic_irq), 0);
    rd(4, v); check("R7 all cleared", v, 0);

    finish_run();
  end
endmodule